// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Error Status

This block turns a single asynchronous serial line into 8-bit characters. It looks for a start bit and confirms it at the middle of the bit. It then shifts in the data least-significant bit first. Depending on the selected mode it takes an optional parity bit. It samples one stop bit and reports the result through two read-only registers: a receive buffer and an error status byte. The bit timing comes from an external oversampling tick, which pulses sixteen times per bit period.

Each completed character raises a one-clock pulse. The status byte carries a parity, a framing and an overrun indication. Software reads the status byte first and the buffer second. Reading the status byte clears every flag. Reading the buffer frees it for the next character. When a character completes while the buffer is still unread, the new character is dropped and the overrun flag is raised. The buffer keeps the older character.

Two enables govern the receiver. Reception begins only once power has been enabled across at least one tick and receive is enabled. Even then, the line must be seen idle high before the first start bit is accepted. With both enables low, the status byte is held at zero.

Top module: `async_rx_core`

## Requirements
- R1: After reset the status byte reads 00h, the buffer reads 00h and `rx_done` is low.
- R2: A start bit is accepted only if the line is still low at the 8th tick after the falling edge. Otherwise the receiver returns to idle without a `rx_done` pulse and without touching any flag. Data bits are sampled every 16 ticks, least-significant bit first.
- R3: `par_mode` selects the parity check: 0 means no parity bit and never a parity error, 1 means the parity bit must be 0, 2 means odd parity over data plus parity bit, and 3 means even parity. A mismatch sets status bit 2.
- R4: A stop bit sampled low sets status bit 1. Only one stop bit is sampled. A character with a parity or framing error is still stored when the buffer is empty.
- R5: When a character completes while the buffer holds unread data, status bit 0 is set, the new data is discarded and the buffer keeps its previous contents.
- R6: A read with `rd_addr`=0 returns the status byte with bits 7..3 at zero and clears all three flags. A flag raised in the same cycle as the read is kept.
- R7: A read with `rd_addr`=1 returns the buffer and marks it empty, so the next character is stored without an overrun.
- R8: While `pwr_en` and `rx_en` are both 0, the status byte reads 00h at once. The flags and the buffer-full state are cleared, so they stay clear after the enables return.
- R9: No character is received unless `pwr_en` has been high across at least one `baud_tick` and `rx_en` is high. Dropping either enable returns the receiver to idle.
- R10: After enabling, and again after every completed character, a start bit is accepted only once the line has been seen high.
- R11: `rx_done` is a one-cycle pulse for each completed character, including overrun characters. The status and buffer reflect that character from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_en | input | 1 | Power enable of the receiver |
| rx_en | input | 1 | Receive enable |
| par_mode | input | 2 | Parity mode: 0 none, 1 zero, 2 odd, 3 even |
| baud_tick | input | 1 | Oversampling tick, 16 per bit |
| rxd | input | 1 | Serial data line, idle high |
| rd_en | input | 1 | Read strobe; side effects occur at the clock edge |
| rd_addr | input | 1 | 0 selects status, 1 selects buffer |
| rd_data | output | 8 | Read data for the selected register |
| rx_done | output | 1 | One-cycle pulse per completed character |

## Verification
The bench builds the receiver with its default parameters: 8 data bits, 16 ticks per bit and a two-stage line synchronizer. It drives a tick every fourth clock. With those values, a character spans a few hundred clocks. That leaves room to place false starts shorter than half a bit, lines held low across the enabling of reception, and back-to-back unread characters. Status and buffer reads can also be placed between a character's `rx_done` and the next start bit. All four parity modes are reached, with both correct and deliberately flipped parity bits.

// File: rtl/async_rx_pkg.sv
package async_rx_pkg;

    localparam int REG_W = 8;

    typedef enum logic [1:0] {
        PAR_NONE = 2'd0,
        PAR_ZERO = 2'd1,
        PAR_ODD  = 2'd2,
        PAR_EVEN = 2'd3
    } par_mode_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP
    } rx_state_e;

    // One completed character as handed from the shifter to the register file
    typedef struct packed {
        logic [REG_W-1:0] data;
        logic             par_err;
        logic             frm_err;
    } rx_frame_t;

    // Packed so that par_err lands on bit 2, frm_err on bit 1, ovr_err on bit 0
    typedef struct packed {
        logic par_err;
        logic frm_err;
        logic ovr_err;
    } rx_flags_t;

    function automatic logic parity_bad(input par_mode_e mode,
                                        input logic [REG_W-1:0] data,
                                        input logic pbit);
        case (mode)
            PAR_ZERO: return pbit;
            PAR_ODD:  return ~(^data ^ pbit);
            PAR_EVEN: return ^data ^ pbit;
            default:  return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/async_rx_sync.sv
module async_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    generate
        if (STAGES <= 1) begin : g_single
            logic stage_q;
            always_ff @(posedge clk) begin
                if (rst) stage_q <= 1'b1;
                else     stage_q <= din;
            end
            assign dout = stage_q;
        end else begin : g_chain
            logic [STAGES-1:0] chain_q;
            always_ff @(posedge clk) begin
                if (rst) chain_q <= '1;
                else     chain_q <= {chain_q[STAGES-2:0], din};
            end
            assign dout = chain_q[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/async_rx_deser.sv
module async_rx_deser
    import async_rx_pkg::*;
#(
    parameter int DATA_BITS  = 8,
    parameter int OVERSAMPLE = 16
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      active,
    input  logic      tick,
    input  logic      rxd_s,
    input  par_mode_e mode,
    output logic      done,
    output rx_frame_t frame,
    output logic      busy
);
    localparam int CNT_W  = $clog2(OVERSAMPLE);
    localparam int BIDX_W = (DATA_BITS > 1) ? $clog2(DATA_BITS) : 1;
    localparam logic [CNT_W-1:0]  MID     = CNT_W'(OVERSAMPLE / 2 - 1);
    localparam logic [CNT_W-1:0]  LAST    = CNT_W'(OVERSAMPLE - 1);
    localparam logic [BIDX_W-1:0] TOP_BIT = BIDX_W'(DATA_BITS - 1);

    rx_state_e             state;
    logic                  armed;
    logic [CNT_W-1:0]      cnt;
    logic [BIDX_W-1:0]     bidx;
    logic [DATA_BITS-1:0]  shreg;
    logic                  pbit;

    assign busy = (state != ST_IDLE);

    always_ff @(posedge clk) begin
        if (rst || !active) begin
            state <= ST_IDLE;
            armed <= 1'b0;
            cnt   <= '0;
            bidx  <= '0;
            shreg <= '0;
            pbit  <= 1'b0;
            done  <= 1'b0;
            frame <= '0;
        end else begin
            done <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    cnt <= '0;
                    if (armed && !rxd_s) state <= ST_START;
                    else if (rxd_s)      armed <= 1'b1;
                end
                ST_START: if (tick) begin
                    if (cnt == MID) begin
                        cnt   <= '0;
                        bidx  <= '0;
                        state <= rxd_s ? ST_IDLE : ST_DATA;
                    end else cnt <= cnt + 1'b1;
                end
                ST_DATA: if (tick) begin
                    if (cnt == LAST) begin
                        cnt   <= '0;
                        shreg <= {rxd_s, shreg[DATA_BITS-1:1]};
                        if (bidx == TOP_BIT)
                            state <= (mode == PAR_NONE) ? ST_STOP : ST_PAR;
                        else
                            bidx <= bidx + 1'b1;
                    end else cnt <= cnt + 1'b1;
                end
                ST_PAR: if (tick) begin
                    if (cnt == LAST) begin
                        cnt   <= '0;
                        pbit  <= rxd_s;
                        state <= ST_STOP;
                    end else cnt <= cnt + 1'b1;
                end
                ST_STOP: if (tick) begin
                    if (cnt == LAST) begin
                        cnt           <= '0;
                        done          <= 1'b1;
                        frame.data    <= REG_W'(shreg);
                        frame.par_err <= parity_bad(mode, REG_W'(shreg), pbit);
                        frame.frm_err <= !rxd_s;
                        armed         <= 1'b0;
                        state         <= ST_IDLE;
                    end else cnt <= cnt + 1'b1;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/async_rx_regs.sv
module async_rx_regs
    import async_rx_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             off,
    input  logic             done,
    input  rx_frame_t        frame,
    input  logic             rd_en,
    input  logic             rd_addr,
    output logic [REG_W-1:0] rd_data,
    output rx_flags_t        flags,
    output logic [REG_W-1:0] buf_q,
    output logic             buf_full
);
    logic      stat_rd, buf_rd, store, lost;
    rx_flags_t new_flags;

    assign stat_rd = rd_en && !rd_addr;
    assign buf_rd  = rd_en && rd_addr;
    // A buffer read in the completion cycle counts as happening first
    assign store   = done && (!buf_full || buf_rd);
    assign lost    = done && buf_full && !buf_rd;

    assign new_flags.par_err = done && frame.par_err;
    assign new_flags.frm_err = done && frame.frm_err;
    assign new_flags.ovr_err = lost;

    always_ff @(posedge clk) begin
        if (rst || off) begin
            flags    <= '0;
            buf_full <= 1'b0;
        end else begin
            flags    <= (stat_rd ? rx_flags_t'('0) : flags) | new_flags;
            buf_full <= store ? 1'b1 : (buf_rd ? 1'b0 : buf_full);
        end
    end

    always_ff @(posedge clk) begin
        if (rst)        buf_q <= '0;
        else if (store) buf_q <= frame.data;
    end

    always_comb begin
        if (rd_addr)  rd_data = buf_q;
        else if (off) rd_data = '0;
        else          rd_data = {{(REG_W-3){1'b0}}, flags};
    end
endmodule

// File: rtl/async_rx_core.sv
module async_rx_core
    import async_rx_pkg::*;
#(
    parameter int DATA_BITS   = 8,
    parameter int OVERSAMPLE  = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pwr_en,
    input  logic             rx_en,
    input  logic [1:0]       par_mode,
    input  logic             baud_tick,
    input  logic             rxd,
    input  logic             rd_en,
    input  logic             rd_addr,
    output logic [REG_W-1:0] rd_data,
    output logic             rx_done
);
    logic             pwr_ok;
    logic             active;
    logic             off;
    logic             rxd_s;
    logic             rx_busy;
    rx_frame_t        frame;
    rx_flags_t        stat_flags;
    logic [REG_W-1:0] buf_q;
    logic             buf_full;

    // Power must have been up across one tick before receive may start
    always_ff @(posedge clk) begin
        if (rst || !pwr_en) pwr_ok <= 1'b0;
        else if (baud_tick) pwr_ok <= 1'b1;
    end

    assign active = pwr_ok && rx_en;
    assign off    = !pwr_en && !rx_en;

    async_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (rxd),
        .dout (rxd_s)
    );

    async_rx_deser #(.DATA_BITS(DATA_BITS), .OVERSAMPLE(OVERSAMPLE)) u_deser (
        .clk    (clk),
        .rst    (rst),
        .active (active),
        .tick   (baud_tick),
        .rxd_s  (rxd_s),
        .mode   (par_mode_e'(par_mode)),
        .done   (rx_done),
        .frame  (frame),
        .busy   (rx_busy)
    );

    async_rx_regs u_regs (
        .clk      (clk),
        .rst      (rst),
        .off      (off),
        .done     (rx_done),
        .frame    (frame),
        .rd_en    (rd_en),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data),
        .flags    (stat_flags),
        .buf_q    (buf_q),
        .buf_full (buf_full)
    );
endmodule

// File: rtl/async_rx_checker.sv
module async_rx_checker
    import async_rx_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             pwr_en,
    input logic             rx_en,
    input logic             rd_en,
    input logic             rd_addr,
    input logic             rx_done,
    input logic             busy,
    input rx_flags_t        flags,
    input logic [REG_W-1:0] buf_q,
    input logic             buf_full
);
    assert_done_pulse_R11: assert property (@(posedge clk) disable iff (rst)
        rx_done |=> !rx_done);

    assert_read_clears_R6: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !rd_addr && !rx_done) |=> (flags == '0));

    assert_off_clears_R8: assert property (@(posedge clk) disable iff (rst)
        (!pwr_en && !rx_en) |=> (flags == '0 && !buf_full));

    assert_overrun_keeps_R5: assert property (@(posedge clk) disable iff (rst)
        (rx_done && buf_full && !(rd_en && rd_addr) && (pwr_en || rx_en))
        |=> (flags.ovr_err && buf_full && $stable(buf_q)));

    assert_store_empty_R4: assert property (@(posedge clk) disable iff (rst)
        (rx_done && !buf_full && (pwr_en || rx_en)) |=> buf_full);

    assert_power_settle_R9: assert property (@(posedge clk) disable iff (rst)
        $past(!pwr_en, 2) |-> !busy);

    assert_enable_gate_R9: assert property (@(posedge clk) disable iff (rst)
        !rx_en |=> !busy);
endmodule

bind async_rx_core async_rx_checker u_chk (
    .clk      (clk),
    .rst      (rst),
    .pwr_en   (pwr_en),
    .rx_en    (rx_en),
    .rd_en    (rd_en),
    .rd_addr  (rd_addr),
    .rx_done  (rx_done),
    .busy     (rx_busy),
    .flags    (stat_flags),
    .buf_q    (buf_q),
    .buf_full (buf_full)
);

// File: tb/test_async_rx_core.sv
module test_async_rx_core;
    localparam int CLK_PERIOD = 10;
    localparam int TICK_DIV   = 4;
    localparam int BIT_TICKS  = 16;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       pwr_en = 1'b0;
    logic       rx_en = 1'b0;
    logic [1:0] par_mode = 2'd0;
    logic       baud_tick = 1'b0;
    logic       rxd = 1'b1;
    logic       rd_en = 1'b0;
    logic       rd_addr = 1'b0;
    logic [7:0] rd_data;
    logic       rx_done;

    int checks = 0;
    int fails  = 0;
    int done_cnt = 0;
    int pushed = 0;

    typedef struct {
        logic [7:0] buf_exp;
        logic [2:0] stat_exp;
        bit         rd_stat;
        bit         rd_buf;
        string      tag;
    } exp_t;
    exp_t q[$];

    // Bench model of what the registers should hold
    logic [2:0] m_flags = 3'b0;
    logic       m_full  = 1'b0;
    logic [7:0] m_buf   = 8'h00;

    async_rx_core i_async_rx_core (
        .clk       (clk),
        .rst       (rst),
        .pwr_en    (pwr_en),
        .rx_en     (rx_en),
        .par_mode  (par_mode),
        .baud_tick (baud_tick),
        .rxd       (rxd),
        .rd_en     (rd_en),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data),
        .rx_done   (rx_done)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    initial begin
        int div = 0;
        forever begin
            @(negedge clk);
            div = (div == TICK_DIV - 1) ? 0 : div + 1;
            baud_tick = (div == TICK_DIV - 1);
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wait_ticks(input int n);
        repeat (n) begin
            @(posedge clk);
            while (!baud_tick) @(posedge clk);
        end
    endtask

    task automatic send_bit(input logic v);
        @(negedge clk);
        rxd = v;
        wait_ticks(BIT_TICKS);
    endtask

    task automatic rd_reg(input logic a, output logic [7:0] v);
        @(negedge clk);
        rd_en = 1'b1;
        rd_addr = a;
        #1;
        v = rd_data;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    // Driver: computes the expected outcome, queues it, then drives the line
    task automatic send_frame(input logic [7:0] d, input logic [1:0] m, input bit flip,
                              input logic stop_lvl, input bit rd_stat, input bit rd_buf,
                              input string tag);
        exp_t it;
        logic pb;
        logic pe;
        logic ov;
        par_mode = m;
        pe = flip && (m != 2'd0);
        ov = m_full;
        if (!m_full) begin
            m_buf = d;
            m_full = 1'b1;
        end
        m_flags = m_flags | {pe, !stop_lvl, ov};
        it.stat_exp = m_flags;
        it.buf_exp  = m_buf;
        it.rd_stat  = rd_stat;
        it.rd_buf   = rd_buf;
        it.tag      = tag;
        if (rd_stat) m_flags = 3'b0;
        if (rd_buf)  m_full = 1'b0;
        q.push_back(it);
        pushed++;
        case (m)
            2'd1:    pb = 1'b0;
            2'd2:    pb = ~^d;
            default: pb = ^d;
        endcase
        send_bit(1'b0);
        for (int i = 0; i < 8; i++) send_bit(d[i]);
        if (m != 2'd0) send_bit(pb ^ flip);
        send_bit(stop_lvl);
        send_bit(1'b1);
        send_bit(1'b1);
    endtask

    // Monitor: pops the expected item on every completion and compares
    initial begin
        exp_t it;
        logic [7:0] v;
        forever begin
            @(negedge clk);
            if (rx_done) begin
                done_cnt++;
                if (q.size() == 0) begin
                    check(1'b0, "R11 unexpected completion", 1, 0);
                end else begin
                    it = q.pop_front();
                    if (it.rd_stat) begin
                        rd_reg(1'b0, v);
                        check(v == {5'b0, it.stat_exp}, it.tag, v, {5'b0, it.stat_exp});
                        rd_reg(1'b0, v);
                        check(v == 8'h00, "R6 status cleared by read", v, 0);
                    end
                    if (it.rd_buf) begin
                        rd_reg(1'b1, v);
                        check(v == it.buf_exp, it.tag, v, it.buf_exp);
                    end
                end
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        logic [7:0] v;
        int base;
        repeat (5) @(negedge clk);
        check(rx_done == 1'b0, "R1 rx_done low in reset", rx_done, 0);
        rst = 1'b0;
        rd_reg(1'b0, v);
        check(v == 8'h00, "R1 status after reset", v, 0);
        rd_reg(1'b1, v);
        check(v == 8'h00, "R1 buffer after reset", v, 0);

        // R9: receive enabled but power off: nothing arrives
        @(negedge clk);
        rx_en = 1'b1;
        base = done_cnt;
        send_bit(1'b0);
        for (int i = 0; i < 10; i++) send_bit(i[0]);
        send_bit(1'b1);
        check(done_cnt == base, "R9 no reception without power", done_cnt, base);
        rd_reg(1'b0, v);
        check(v == 8'h00, "R9 status untouched", v, 0);

        // R10: receive enabled while the line is low
        @(negedge clk);
        rx_en = 1'b0;
        pwr_en = 1'b1;
        wait_ticks(4);
        @(negedge clk);
        rxd = 1'b0;
        wait_ticks(2);
        @(negedge clk);
        rx_en = 1'b1;
        base = done_cnt;
        wait_ticks(40);
        @(negedge clk);
        rxd = 1'b1;
        wait_ticks(BIT_TICKS);
        check(done_cnt == base, "R10 low line at enable ignored", done_cnt, base);

        // Good characters in every parity mode
        send_frame(8'hA5, 2'd3, 1'b0, 1'b1, 1, 1, "R2 R3 even parity good");
        send_frame(8'h3C, 2'd2, 1'b0, 1'b1, 1, 1, "R3 odd parity good");
        send_frame(8'h81, 2'd1, 1'b0, 1'b1, 1, 1, "R3 zero parity good");
        send_frame(8'h7E, 2'd0, 1'b0, 1'b1, 1, 1, "R3 no parity never errs");
        // Parity errors
        send_frame(8'h5A, 2'd3, 1'b1, 1'b1, 1, 1, "R3 even parity bad");
        send_frame(8'h01, 2'd2, 1'b1, 1'b1, 1, 1, "R3 odd parity bad");
        send_frame(8'hF0, 2'd1, 1'b1, 1'b1, 1, 1, "R3 zero parity bad");
        // Framing errors, stored anyway
        send_frame(8'hC3, 2'd0, 1'b0, 1'b0, 1, 1, "R4 low stop bit");
        send_frame(8'h96, 2'd3, 1'b1, 1'b0, 1, 1, "R4 parity and stop bad");
        send_frame(8'h69, 2'd2, 1'b0, 1'b1, 1, 1, "R10 rearm after low stop");

        // R2 false start
        base = done_cnt;
        @(negedge clk);
        rxd = 1'b0;
        wait_ticks(4);
        @(negedge clk);
        rxd = 1'b1;
        wait_ticks(2 * BIT_TICKS);
        check(done_cnt == base, "R2 false start rejected", done_cnt, base);
        rd_reg(1'b0, v);
        check(v == 8'h00, "R2 false start leaves flags", v, 0);

        // R5 overrun, then R7 buffer freed
        send_frame(8'h11, 2'd0, 1'b0, 1'b1, 1, 0, "R5 first unread");
        send_frame(8'h22, 2'd0, 1'b0, 1'b1, 1, 1, "R5 overrun keeps old");
        send_frame(8'h33, 2'd0, 1'b0, 1'b1, 1, 1, "R7 store after buffer read");

        // R8 disable clears flags and full state
        send_frame(8'h44, 2'd3, 1'b1, 1'b1, 0, 0, "R8 pending");
        q.delete();
        @(negedge clk);
        pwr_en = 1'b0;
        rx_en = 1'b0;
        rd_addr = 1'b0;
        #1;
        check(rd_data == 8'h00, "R8 status reads zero when off", rd_data, 0);
        m_flags = 3'b0;
        m_full = 1'b0;
        wait_ticks(2);
        @(negedge clk);
        pwr_en = 1'b1;
        rx_en = 1'b1;
        wait_ticks(4);
        rd_reg(1'b0, v);
        check(v == 8'h00, "R8 flags cleared not masked", v, 0);
        send_frame(8'h55, 2'd0, 1'b0, 1'b1, 1, 1, "R8 no overrun after off");

        wait_ticks(4);
        check(q.size() == 0, "R11 all completions seen", q.size(), 0);
        check(done_cnt == pushed, "R11 one pulse per character", done_cnt, pushed);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule